// File: doc/BRIEF.md
# Doorbell Write Dispatcher

This block sits behind a bank of write-only doorbell registers in a host controller. Each write names a doorbell index and carries a 32-bit value. The block splits that value into a target code and a stream identifier, then routes it by index. Index zero belongs to the command ring: a well-formed write there starts the ring and raises a sticky running flag. Indices one and up belong to device slots: a write there becomes a one-cycle ring request tagged with the slot number, target and stream.

All of this happens only while the controller's run/stop input is high. A write to an index beyond the configured slot count produces an error pulse rather than a request. Every result is registered, so it appears on the outputs in the cycle after the write. Reads of the bank are acknowledged one cycle later with all-zero data.

Top module: `doorbell_dispatch`

## Requirements
- R1: The target is wr_data[7:0] and the stream ID is wr_data[31:16]. Bits 15:8 have no effect on any output.
- R2: While run_stop is low, a write produces no cmd_start, no req_valid and no slot_err.
- R3: While running, a write to index 0 is ignored if its target or its stream ID is nonzero. It produces no cmd_start and leaves cmd_running unchanged.
- R4: While running, a write to index 0 with zero target and zero stream ID pulses cmd_start for one cycle in the cycle after the write. In that same cycle cmd_running is high.
- R5: While running, a write to index k with 1 <= k <= NUM_SLOTS pulses req_valid in the cycle after the write, with req_slot = k and req_target and req_stream taken from that write.
- R6: While running, a write to an index above NUM_SLOTS pulses slot_err in the cycle after the write and raises no req_valid.
- R7: cmd_running stays set until run_stop is sampled low. It is low in the cycle after any cycle in which run_stop was low.
- R8: A read (rd_en) is acknowledged on rd_ack in the next cycle, and rd_data is always zero.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_stop | input | 1 | Controller running when high |
| wr_en | input | 1 | Doorbell write strobe |
| wr_idx | input | IDX_W | Doorbell index of the write |
| wr_data | input | DATA_W | Written doorbell value |
| rd_en | input | 1 | Doorbell read strobe |
| rd_ack | output | 1 | Read acknowledge, one cycle after rd_en |
| rd_data | output | DATA_W | Read data, always zero |
| cmd_start | output | 1 | One-cycle command ring start pulse |
| cmd_running | output | 1 | Command ring running flag |
| req_valid | output | 1 | One-cycle slot ring request |
| req_slot | output | IDX_W | Slot number of the request |
| req_target | output | TGT_W | Target code of the request |
| req_stream | output | DATA_W-SID_LSB | Stream ID of the request |
| slot_err | output | 1 | Pulse when the index is beyond NUM_SLOTS |

## Verification
The bench builds the block with NUM_SLOTS = 5 and a 4-bit index. At that size both the last valid slot (5) and several out-of-range indices (6 and 15) are reachable from the port, so the boundary between request and error is exercised from both sides. The narrow index does not change the 32-bit field split, so target and stream extraction, including all-ones and reserved-only patterns, runs at full width.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_CMD  = 2'd1,
    DB_SLOT = 2'd2,
    DB_ERR  = 2'd3
  } db_kind_e;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int TGT_W     = 8,
  parameter int SID_LSB   = 16
) (
  input  logic                      run_stop,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output db_kind_e                  kind,
  output logic [TGT_W-1:0]          tgt,
  output logic [DATA_W-SID_LSB-1:0] sid
);
  localparam int SID_W = DATA_W - SID_LSB;

  logic [31:0] idx_ext;
  logic        unused_resv;

  assign tgt         = wr_data[TGT_W-1:0];
  assign sid         = wr_data[DATA_W-1:SID_LSB];
  assign unused_resv = ^wr_data[SID_LSB-1:TGT_W];
  assign idx_ext     = 32'(wr_idx);

  always_comb begin
    kind = DB_NONE;
    if (wr_en && run_stop) begin
      if (idx_ext == 32'd0) begin
        if ((tgt == '0) && (sid == SID_W'(0))) kind = DB_CMD;
      end else if (idx_ext <= 32'(NUM_SLOTS)) begin
        kind = DB_SLOT;
      end else begin
        kind = DB_ERR;
      end
    end
  end
endmodule

// File: rtl/db_ring_state.sv
module db_ring_state (
  input  logic clk,
  input  logic rst_n,
  input  logic run_stop,
  input  logic start_req,
  output logic running
);
  logic running_d;
  logic running_q;

  always_comb begin
    running_d = running_q;
    if (!run_stop)      running_d = 1'b0;
    else if (start_req) running_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) running_q <= 1'b0;
    else        running_q <= running_d;
  end

  assign running = running_q;

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run_stop |=> !running_q); // R7
endmodule

// File: rtl/db_issue.sv
module db_issue
  import db_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_SLOTS = 32,
  parameter int TGT_W     = 8,
  parameter int SID_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  db_kind_e         kind,
  input  logic [IDX_W-1:0] idx,
  input  logic [TGT_W-1:0] tgt,
  input  logic [SID_W-1:0] sid,
  output logic             cmd_start,
  output logic             req_valid,
  output logic [IDX_W-1:0] req_slot,
  output logic [TGT_W-1:0] req_target,
  output logic [SID_W-1:0] req_stream,
  output logic             slot_err
);
  logic             start_d, valid_d, err_d, load_en;
  logic             start_q, valid_q, err_q;
  logic [IDX_W-1:0] slot_q;
  logic [TGT_W-1:0] tgt_q;
  logic [SID_W-1:0] sid_q;

  always_comb begin
    start_d = (kind == DB_CMD);
    valid_d = (kind == DB_SLOT);
    err_d   = (kind == DB_ERR);
    load_en = valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      tgt_q  <= '0;
      sid_q  <= '0;
    end else if (load_en) begin
      slot_q <= idx;
      tgt_q  <= tgt;
      sid_q  <= sid;
    end
  end

  assign cmd_start  = start_q;
  assign req_valid  = valid_q;
  assign req_slot   = slot_q;
  assign req_target = tgt_q;
  assign req_stream = sid_q;
  assign slot_err   = err_q;

  AST_REQ_NOT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && err_q)); // R6
  AST_REQ_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (32'(slot_q) >= 32'd1 && 32'(slot_q) <= 32'(NUM_SLOTS))); // R5
endmodule

// File: rtl/doorbell_dispatch.sv
module doorbell_dispatch
  import db_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_SLOTS = 32,
  parameter int DATA_W    = 32,
  parameter int TGT_W     = 8,
  parameter int SID_LSB   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_stop,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      rd_en,
  output logic                      rd_ack,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      cmd_start,
  output logic                      cmd_running,
  output logic                      req_valid,
  output logic [IDX_W-1:0]          req_slot,
  output logic [TGT_W-1:0]          req_target,
  output logic [DATA_W-SID_LSB-1:0] req_stream,
  output logic                      slot_err
);
  localparam int SID_W = DATA_W - SID_LSB;

  db_kind_e         kind;
  logic [TGT_W-1:0] dec_tgt;
  logic [SID_W-1:0] dec_sid;
  logic             rd_ack_d, rd_ack_q;

  db_decode #(
    .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W),
    .TGT_W(TGT_W), .SID_LSB(SID_LSB)
  ) u_decode (
    .run_stop(run_stop), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .kind(kind), .tgt(dec_tgt), .sid(dec_sid)
  );

  db_ring_state u_ring (
    .clk(clk), .rst_n(rst_n), .run_stop(run_stop),
    .start_req(kind == DB_CMD), .running(cmd_running)
  );

  db_issue #(
    .IDX_W(IDX_W), .NUM_SLOTS(NUM_SLOTS), .TGT_W(TGT_W), .SID_W(SID_W)
  ) u_issue (
    .clk(clk), .rst_n(rst_n), .kind(kind), .idx(wr_idx),
    .tgt(dec_tgt), .sid(dec_sid),
    .cmd_start(cmd_start), .req_valid(req_valid), .req_slot(req_slot),
    .req_target(req_target), .req_stream(req_stream), .slot_err(slot_err)
  );

  always_comb rd_ack_d = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ack_q <= 1'b0;
    else        rd_ack_q <= rd_ack_d;
  end

  assign rd_ack  = rd_ack_q;
  assign rd_data = '0;

  AST_START_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> cmd_running); // R4
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !run_stop |=> !(cmd_start || req_valid || slot_err)); // R2
  AST_DB0_BAD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && run_stop && wr_idx == '0 && (wr_data[TGT_W-1:0] != '0 || wr_data[DATA_W-1:SID_LSB] != '0))
      |=> !cmd_start); // R3
endmodule

// File: tb/doorbell_dispatch_tb.sv
module doorbell_dispatch_tb;
  localparam int IDX_W = 4;
  localparam int NSL   = 5;

  logic        clk = 1'b0;
  logic        rst_n, run_stop, wr_en, rd_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data, rd_data;
  logic        rd_ack, cmd_start, cmd_running, req_valid, slot_err;
  logic [3:0]  req_slot;
  logic [7:0]  req_target;
  logic [15:0] req_stream;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected item: kind 0 none,1 cmd,2 slot,3 err
  int          q_kind[$];
  logic [3:0]  q_slot[$];
  logic [7:0]  q_tgt[$];
  logic [15:0] q_sid[$];
  bit          q_run[$];
  string       q_tag[$];
  bit          exp_running = 0;

  always #10 clk = ~clk;

  doorbell_dispatch #(.IDX_W(IDX_W), .NUM_SLOTS(NSL)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_stop(run_stop), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_en(rd_en), .rd_ack(rd_ack),
    .rd_data(rd_data), .cmd_start(cmd_start), .cmd_running(cmd_running),
    .req_valid(req_valid), .req_slot(req_slot), .req_target(req_target),
    .req_stream(req_stream), .slot_err(slot_err)
  );

  task automatic push(input int k, input logic [3:0] s, input logic [7:0] t,
                      input logic [15:0] d, input string tag);
    q_kind.push_back(k); q_slot.push_back(s); q_tgt.push_back(t);
    q_sid.push_back(d); q_run.push_back(exp_running); q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] data, input string tag);
    int k;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = data; rd_en = 1'b0;
    k = 0;
    if (run_stop) begin
      if (idx == 0) k = (data[7:0] == 0 && data[31:16] == 0) ? 1 : 0;
      else if (int'(idx) <= NSL) k = 2;
      else k = 3;
    end
    if (!run_stop) exp_running = 0;
    else if (k == 1) exp_running = 1;
    push(k, idx, data[7:0], data[31:16], tag);
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (!run_stop) exp_running = 0;
    push(0, '0, '0, '0, tag);
  endtask

  task automatic set_run(input logic v, input string tag);
    @(negedge clk);
    run_stop = v; wr_en = 1'b0; rd_en = 1'b0;
    if (!v) exp_running = 0;
    push(0, '0, '0, '0, tag);
  endtask

  task automatic check(input bit ok, input string tag, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, msg);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk); #5;
      if (q_kind.size() > 0) begin
        int k; logic [3:0] s; logic [7:0] t; logic [15:0] d; bit r; string tag;
        k = q_kind.pop_front(); s = q_slot.pop_front(); t = q_tgt.pop_front();
        d = q_sid.pop_front(); r = q_run.pop_front(); tag = q_tag.pop_front();
        check(cmd_start == (k == 1) && req_valid == (k == 2) && slot_err == (k == 3)
              && cmd_running == r, tag,
              $sformatf("start/valid/err/running act=%b%b%b%b exp=%b%b%b%b",
                        cmd_start, req_valid, slot_err, cmd_running,
                        k == 1, k == 2, k == 3, r));
        if (k == 2)
          check(req_slot == s && req_target == t && req_stream == d, tag,
                $sformatf("slot/tgt/sid act=%0d/%h/%h exp=%0d/%h/%h",
                          req_slot, req_target, req_stream, s, t, d));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_stop = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_idx = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #5;
    check({rd_ack, cmd_start, cmd_running, req_valid, slot_err} == 5'b0 &&
          req_slot == 0 && req_target == 0 && req_stream == 0 && rd_data == 0,
          "R9", $sformatf("outputs act=%b exp=0",
          {rd_ack, cmd_start, cmd_running, req_valid, slot_err}));
    @(negedge clk); rst_n = 1'b1;

    wr(4'd0, 32'h0, "R2");
    wr(4'd2, 32'h0003_0005, "R2");
    wr(4'd9, 32'h0, "R2");
    idle("R2");
    set_run(1'b1, "R7");
    wr(4'd0, 32'h0000_FF00, "R1");   // reserved bits only: valid start
    idle("R4");
    set_run(1'b0, "R7");
    idle("R7");
    set_run(1'b1, "R7");
    wr(4'd0, 32'h0000_0001, "R3");
    wr(4'd0, 32'h0001_0000, "R3");
    wr(4'd1, 32'hABCD_12EF, "R5");
    wr(4'd5, 32'h0001_FF02, "R5");
    wr(4'd3, 32'hFFFF_FFFF, "R1");
    wr(4'd6, 32'h0000_0001, "R6");
    wr(4'd15, 32'h1234_0000, "R6");
    wr(4'd0, 32'h0, "R4");
    wr(4'd2, 32'h0000_0000, "R5");
    wr(4'd0, 32'h0000_0080, "R3");
    idle("R4");

    @(negedge clk); rd_en = 1'b1;
    @(posedge clk); #5;
    check(rd_ack == 1'b1 && rd_data == 32'h0, "R8",
          $sformatf("rd_ack/rd_data act=%b/%h exp=1/0", rd_ack, rd_data));
    @(negedge clk); rd_en = 1'b0;

    set_run(1'b0, "R7");
    wr(4'd1, 32'h0002_0003, "R2");
    wr(4'd0, 32'h0, "R2");
    idle("R2");
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule